// File: doc/BRIEF.md
# Dual Host Interrupt Line Controller

This block turns internal event pulses into two active-low interrupt lines for a host processor. One line carries hardware events and the other carries message events. Each event bus is gated by its own enable vector. Enabled events set bits in a pending register that the host can read. Each enabled event also raises the matching interrupt line.

A single mode input chooses how both lines behave. In pulse mode a line drops low for a fixed number of clocks and then returns high. In level mode a line stays low until the host clears it. The host clears a line in one of two ways: it holds the line's acknowledge input high long enough to pass a filter, or it strobes a read of the pending register. A build-time option merges the two acknowledges, so that either one clears both lines.

The block also keeps a history of recent events. Every cycle that has at least one enabled event stores one record in a circular memory. The host can read the write pointer and any record.

Top module: `irq_out_ctrl`

## Requirements
- R1: After a synchronous reset, both interrupt lines are high, the pending register is zero and the log write pointer is zero.
- R2: An event bit whose enable bit is low changes neither line, nor the pending register, nor the log.
- R3: With `level_mode` = 0 (pulse mode), an enabled event drives its line low for exactly 4 clocks, starting the cycle after the event. A new event during the pulse restarts the 4-clock count.
- R4: With `level_mode` = 1 (level mode), an enabled event drives its line low from the next cycle, and the line stays low until it is cleared. Further events that arrive while the line is low keep it low and are ORed into the pending register.
- R5: In level mode, an acknowledge input held high for 3 consecutive clocks drives its line high again. The line is high no later than the 5th rising edge after the first edge that samples the acknowledge high. An acknowledge held for only 2 clocks does nothing. An acknowledge never changes the pending register.
- R6: In pulse mode, the acknowledge inputs have no effect on the lines.
- R7: A `pend_rd` strobe clears the pending register. In level mode it also drives both lines high. An event that arrives in the same cycle as the strobe wins: its bits stay pending, and its line goes low or stays low.
- R8: In `pend_bits`, bits [HW_W-1:0] hold the hardware events and bits [HW_W+MSG_W-1:HW_W] hold the message events.
- R9: Each cycle that has any enabled event writes one record, {message hits, hardware hits}, at `log_wptr`. The pointer then advances modulo 16, so the oldest record is overwritten. `log_rdata` shows the record at `log_raddr` one clock after the address is presented.
- R10: When `MERGED_ACK` = 1, an acknowledge accepted on either input clears both lines in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_mode | input | 1 | 1 = level lines, 0 = pulse lines |
| hw_evt | input | HW_W | Hardware event pulses |
| hw_en | input | HW_W | Hardware event enables |
| msg_evt | input | MSG_W | Message event pulses |
| msg_en | input | MSG_W | Message event enables |
| ack_hw | input | 1 | Acknowledge for the hardware line |
| ack_msg | input | 1 | Acknowledge for the message line |
| pend_rd | input | 1 | Host read strobe for the pending register |
| irq_hw_n | output | 1 | Hardware interrupt line, active low |
| irq_msg_n | output | 1 | Message interrupt line, active low |
| pend_bits | output | HW_W+MSG_W | Pending register |
| log_raddr | input | LOG_AW | History read address |
| log_rdata | output | HW_W+MSG_W | History record, registered |
| log_wptr | output | LOG_AW | History write pointer |

## Verification
A pending-register read and a fresh event can arrive in the same clock, and the clear must not drop the new event. The bench provokes this in two places. In the vector table, a row carries `pend_rd` together with enabled hardware and message bits, and the expected pending value is exactly those new bits. In a directed test, a read and a message event arrive in the same cycle in level mode; the message line must go low while the hardware line goes high. The bench also raises the message acknowledge while both level lines are low, which shows the separate acknowledges next to the merged variant.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    IRQ_PULSE = 1'b0,
    IRQ_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/ack_filter.sv
// Two-flop synchronizer followed by a run-length qualifier.
// accept is a single-cycle pulse once the input has been high HOLD_CLKS clocks in a row.
module ack_filter #(
  parameter int HOLD_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_in,
  output logic accept
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic          sync1, sync2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      run   <= '0;
    end else begin
      sync1 <= ack_in;
      sync2 <= sync1;
      if (!sync2)
        run <= '0;
      else if (run != CW'(HOLD_CLKS))
        run <= run + 1'b1;
    end
  end

  assign accept = sync2 && (run == CW'(HOLD_CLKS - 1));
endmodule

// File: rtl/irq_line.sv
// One active-low interrupt line. In pulse mode it is driven by a down counter;
// in level mode by a sticky flag. The output is registered.
module irq_line
  import irq_pkg::*;
#(
  parameter int PULSE_CLKS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  irq_mode_e mode,
  input  logic      fire,
  input  logic      ack_ok,
  input  logic      rd_clr,
  output logic      irq_n
);
  localparam int PW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] cnt, cnt_nx;
  logic          lvl, lvl_nx;

  always_comb begin
    if (mode == IRQ_LEVEL) begin
      cnt_nx = '0;
      lvl_nx = fire | (lvl & ~ack_ok & ~rd_clr);
    end else begin
      lvl_nx = 1'b0;
      if (fire)
        cnt_nx = PW'(PULSE_CLKS);
      else if (cnt != '0)
        cnt_nx = cnt - 1'b1;
      else
        cnt_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lvl   <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      lvl   <= lvl_nx;
      irq_n <= ~(lvl_nx | (cnt_nx != '0));
    end
  end
endmodule

// File: rtl/event_log.sv
// Circular history memory with a synchronous read port, so block RAM can be inferred.
module event_log #(
  parameter int EW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [EW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [EW-1:0]            rd_data,
  output logic [$clog2(DEPTH)-1:0] wptr
);
  localparam int AW = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)
      wptr <= '0;
    else if (wr_en)
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
  end
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_pkg::*;
#(
  parameter int HW_W       = 8,
  parameter int MSG_W      = 8,
  parameter int PULSE_CLKS = 4,
  parameter int ACK_CLKS   = 3,
  parameter int LOG_DEPTH  = 16,
  parameter bit MERGED_ACK = 1'b0,
  localparam int PW        = HW_W + MSG_W,
  localparam int LOG_AW    = $clog2(LOG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              level_mode,
  input  logic [HW_W-1:0]   hw_evt,
  input  logic [HW_W-1:0]   hw_en,
  input  logic [MSG_W-1:0]  msg_evt,
  input  logic [MSG_W-1:0]  msg_en,
  input  logic              ack_hw,
  input  logic              ack_msg,
  input  logic              pend_rd,
  output logic              irq_hw_n,
  output logic              irq_msg_n,
  output logic [PW-1:0]     pend_bits,
  input  logic [LOG_AW-1:0] log_raddr,
  output logic [PW-1:0]     log_rdata,
  output logic [LOG_AW-1:0] log_wptr
);
  irq_mode_e         mode;
  logic [HW_W-1:0]   hw_hit;
  logic [MSG_W-1:0]  msg_hit;
  logic [PW-1:0]     hits;
  logic              any_hit;
  logic              acc_hw, acc_msg;

  assign mode    = irq_mode_e'(level_mode);
  assign hw_hit  = hw_evt & hw_en;
  assign msg_hit = msg_evt & msg_en;
  assign hits    = {msg_hit, hw_hit};
  assign any_hit = |hits;

  // Pending register: a read clears it, and events of the same cycle are kept.
  always_ff @(posedge clk) begin
    if (rst)
      pend_bits <= '0;
    else if (pend_rd)
      pend_bits <= hits;
    else
      pend_bits <= pend_bits | hits;
  end

  generate
    if (MERGED_ACK) begin : g_ack_merged
      logic acc_any;
      ack_filter #(.HOLD_CLKS(ACK_CLKS)) u_ack (
        .clk(clk), .rst(rst), .ack_in(ack_hw | ack_msg), .accept(acc_any));
      assign acc_hw  = acc_any;
      assign acc_msg = acc_any;
    end else begin : g_ack_split
      ack_filter #(.HOLD_CLKS(ACK_CLKS)) u_ack_hw (
        .clk(clk), .rst(rst), .ack_in(ack_hw), .accept(acc_hw));
      ack_filter #(.HOLD_CLKS(ACK_CLKS)) u_ack_msg (
        .clk(clk), .rst(rst), .ack_in(ack_msg), .accept(acc_msg));
    end
  endgenerate

  irq_line #(.PULSE_CLKS(PULSE_CLKS)) u_line_hw (
    .clk(clk), .rst(rst), .mode(mode), .fire(|hw_hit),
    .ack_ok(acc_hw), .rd_clr(pend_rd), .irq_n(irq_hw_n));

  irq_line #(.PULSE_CLKS(PULSE_CLKS)) u_line_msg (
    .clk(clk), .rst(rst), .mode(mode), .fire(|msg_hit),
    .ack_ok(acc_msg), .rd_clr(pend_rd), .irq_n(irq_msg_n));

  event_log #(.EW(PW), .DEPTH(LOG_DEPTH)) u_log (
    .clk(clk), .rst(rst), .wr_en(any_hit), .wr_data(hits),
    .rd_addr(log_raddr), .rd_data(log_rdata), .wptr(log_wptr));
endmodule

// File: rtl/irq_out_ctrl_chk.sv
module irq_out_ctrl_chk #(
  parameter int HW_W      = 8,
  parameter int MSG_W     = 8,
  parameter int LOG_DEPTH = 16,
  localparam int PW       = HW_W + MSG_W,
  localparam int LOG_AW   = $clog2(LOG_DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              level_mode,
  input logic [HW_W-1:0]   hw_evt,
  input logic [HW_W-1:0]   hw_en,
  input logic [MSG_W-1:0]  msg_evt,
  input logic [MSG_W-1:0]  msg_en,
  input logic              pend_rd,
  input logic              irq_hw_n,
  input logic              irq_msg_n,
  input logic [PW-1:0]     pend_bits,
  input logic [LOG_AW-1:0] log_wptr
);
  logic hw_any, msg_any;
  assign hw_any  = |(hw_evt & hw_en);
  assign msg_any = |(msg_evt & msg_en);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (irq_hw_n && irq_msg_n && pend_bits == '0 && log_wptr == '0));

  assert_level_assert_R4: assert property (@(posedge clk) disable iff (rst)
    (level_mode && hw_any) |=> !irq_hw_n);

  assert_pulse_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && !hw_any && irq_hw_n) |=> irq_hw_n);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (level_mode && pend_rd && !hw_any && !msg_any) |=> (irq_hw_n && irq_msg_n && pend_bits == '0));

  assert_pending_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !pend_rd |=> ((pend_bits & $past(pend_bits)) == $past(pend_bits)));

  assert_log_advance_R9: assert property (@(posedge clk) disable iff (rst)
    (hw_any || msg_any) |=> (log_wptr == LOG_AW'($past(log_wptr) + 1'b1)));
endmodule

bind irq_out_ctrl irq_out_ctrl_chk #(.HW_W(HW_W), .MSG_W(MSG_W), .LOG_DEPTH(LOG_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .level_mode(level_mode), .hw_evt(hw_evt), .hw_en(hw_en),
  .msg_evt(msg_evt), .msg_en(msg_en), .pend_rd(pend_rd), .irq_hw_n(irq_hw_n),
  .irq_msg_n(irq_msg_n), .pend_bits(pend_bits), .log_wptr(log_wptr));

// File: tb/sim_irq_out_ctrl.sv
`timescale 1ns/1ps
module sim_irq_out_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic level_mode = 1'b1;
  logic [7:0] hw_evt = '0, hw_en = 8'h0F, msg_evt = '0, msg_en = 8'hF0;
  logic ack_hw = 1'b0, ack_msg = 1'b0, pend_rd = 1'b0;
  logic [3:0] log_raddr = '0;
  logic irq_hw_n, irq_msg_n, m_hw_n, m_msg_n;
  logic [15:0] pend_bits, log_rdata, m_pend, m_rdata;
  logic [3:0] log_wptr, m_wptr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_out_ctrl u0 (
    .clk(clk), .rst(rst), .level_mode(level_mode), .hw_evt(hw_evt), .hw_en(hw_en),
    .msg_evt(msg_evt), .msg_en(msg_en), .ack_hw(ack_hw), .ack_msg(ack_msg),
    .pend_rd(pend_rd), .irq_hw_n(irq_hw_n), .irq_msg_n(irq_msg_n), .pend_bits(pend_bits),
    .log_raddr(log_raddr), .log_rdata(log_rdata), .log_wptr(log_wptr));

  irq_out_ctrl #(.MERGED_ACK(1'b1)) u1 (
    .clk(clk), .rst(rst), .level_mode(level_mode), .hw_evt(hw_evt), .hw_en(hw_en),
    .msg_evt(msg_evt), .msg_en(msg_en), .ack_hw(ack_hw), .ack_msg(ack_msg),
    .pend_rd(pend_rd), .irq_hw_n(m_hw_n), .irq_msg_n(m_msg_n), .pend_bits(m_pend),
    .log_raddr(log_raddr), .log_rdata(m_rdata), .log_wptr(m_wptr));

  // {pend_rd, hw_evt, msg_evt, expected pend_bits}; hw_en = 0F, msg_en = F0
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'h01, 8'h00, 16'h0001},
    {1'b0, 8'h10, 8'h01, 16'h0001},
    {1'b0, 8'h02, 8'h10, 16'h1003},
    {1'b1, 8'h00, 8'h00, 16'h0000},
    {1'b1, 8'h04, 8'h20, 16'h2004},
    {1'b0, 8'h08, 8'h80, 16'hA00C},
    {1'b1, 8'h00, 8'h00, 16'h0000},
    {1'b0, 8'hFF, 8'hFF, 16'hF00F}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lows;
    step(1);
    do_reset();
    // R1 reset state
    chk("R1 lines", {30'd0, irq_hw_n, irq_msg_n}, 32'd3);
    chk("R1 pend", pend_bits, 0);
    chk("R1 wptr", log_wptr, 0);

    // Vector table: pending accumulation, masking (R2, R8) and read collision (R7)
    for (int k = 0; k < 8; k++) begin
      pend_rd = VEC[k][32];
      hw_evt  = VEC[k][31:24];
      msg_evt = VEC[k][23:16];
      step(1);
      chk("R8 pending vector", pend_bits, VEC[k][15:0]);
    end
    pend_rd = 0; hw_evt = 0; msg_evt = 0;
    chk("R2 masked rows skip log", log_wptr, 5);
    log_raddr = 4'd1; step(1);
    chk("R9 log record 1", log_rdata, 16'h1002);
    log_raddr = 4'd4; step(1);
    chk("R9 log record 4", log_rdata, 16'hF00F);

    do_reset();
    chk("R1 pend after reset", pend_bits, 0);

    // Pulse mode with acknowledge held (R3, R6)
    level_mode = 1'b0;
    hw_evt = 8'h01; ack_hw = 1'b1;
    step(1);
    hw_evt = 0;
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      if (!irq_hw_n) lows++;
      step(1);
    end
    ack_hw = 1'b0;
    chk("R3 pulse width", lows, 4);
    chk("R6 ack ignored in pulse", irq_hw_n, 1);
    // masked-only event leaves lines alone (R2)
    hw_evt = 8'hF0; msg_evt = 8'h0F; step(1); hw_evt = 0; msg_evt = 0;
    chk("R2 masked lines", {30'd0, irq_hw_n, irq_msg_n}, 32'd3);

    // Level mode (R4, R5)
    do_reset();
    level_mode = 1'b1;
    hw_evt = 8'h01; step(1); hw_evt = 0;
    chk("R4 level low", irq_hw_n, 0);
    step(10);
    chk("R4 level held", irq_hw_n, 0);
    hw_evt = 8'h02; step(1); hw_evt = 0;
    chk("R4 OR into pending", pend_bits, 16'h0003);
    ack_hw = 1'b1; step(2); ack_hw = 1'b0; step(6);
    chk("R5 short ack rejected", irq_hw_n, 0);
    ack_hw = 1'b1; step(3); ack_hw = 1'b0; step(3);
    chk("R5 ack accepted", irq_hw_n, 1);
    chk("R5 pending kept", pend_bits, 16'h0003);

    // Separate vs merged acknowledge (R10)
    msg_evt = 8'h10; hw_evt = 8'h01; step(1); msg_evt = 0; hw_evt = 0;
    ack_msg = 1'b1; step(3); ack_msg = 1'b0; step(3);
    chk("R5 msg ack split", {30'd0, irq_hw_n, irq_msg_n}, 32'd1);
    chk("R10 merged ack", {30'd0, m_hw_n, m_msg_n}, 32'd3);

    // Pending read clears (R7)
    msg_evt = 8'h10; step(1); msg_evt = 0;
    pend_rd = 1'b1; step(1); pend_rd = 1'b0;
    chk("R7 read clears lines", {30'd0, irq_hw_n, irq_msg_n}, 32'd3);
    chk("R7 read clears pending", pend_bits, 0);
    hw_evt = 8'h01; step(1); hw_evt = 0;
    pend_rd = 1'b1; msg_evt = 8'h20; step(1); pend_rd = 1'b0; msg_evt = 0;
    chk("R7 collision lines", {30'd0, irq_hw_n, irq_msg_n}, 32'd2);
    chk("R7 collision pending", pend_bits, 16'h2000);

    // Log wrap (R9)
    do_reset();
    level_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      hw_evt = 8'((i % 15) + 1);
      step(1);
    end
    hw_evt = 0;
    chk("R9 wptr wrap", log_wptr, 4);
    log_raddr = 4'd0; step(1);
    chk("R9 overwritten oldest", log_rdata, 16'h0002);
    log_raddr = 4'd3; step(1);
    chk("R9 newest record", log_rdata, 16'h0005);
    log_raddr = 4'd15; step(1);
    chk("R9 record 15", log_rdata, 16'h0001);

    finish_run();
  end
endmodule